// File: doc/BRIEF.md
# Paged Memory Bank Mapper

The mapper sits between a 16-bit CPU address bus and a physical memory larger than 64 KB. The CPU space is cut into four 16 KB windows chosen by the top two address bits. Each window has its own 8-bit page register, and any physical 16 KB page can be shown in any window. The physical address is the selected page number joined to the low 14 CPU address bits, which gives 22 bits.

After reset the mapper is in compatibility mode: window n always shows physical page n, whatever the page registers hold. Software configures the mapper through a single I/O port that nothing else decodes. A command byte written there sets the enhanced-mode enable and picks a window. It can also announce that the next write to the port is a page number for that window. Every configuration write is first held in a small sequencer. The write is applied on the next clock edge on which no memory cycle is in progress, so a mapping never changes partway through a memory access.

The sequencer has four states. CMD waits for a command byte. CMD_HOLD holds a command until the memory bus is idle. PAGE waits for a page byte. PAGE_HOLD holds a page byte until the bus is idle. The transitions are:
- CMD goes to CMD_HOLD on a port write.
- CMD_HOLD goes to PAGE when it applies a command that has the load flag set, and to CMD when it applies one without it.
- PAGE goes to PAGE_HOLD on a port write.
- PAGE_HOLD goes to CMD when it applies the page byte.

Top module: `page_mapper`

## Requirements
- R1: In compatibility mode, the physical address is {6'b0, cpu_addr[15:14], cpu_addr[13:0]} for every address, whatever the page registers hold.
- R2: After reset, the page registers of windows 0 to 3 hold 0, 1, 2 and 3, the mode is compatibility, and the selected window is 0.
- R3: Page bytes loaded while in compatibility mode do not change the physical address until enhanced mode is turned on.
- R4: In enhanced mode, the physical address is {page[w], cpu_addr[13:0]}, where w = cpu_addr[15:14]. Any 8-bit page value can be placed in any window.
- R5: Turning on enhanced mode while the registers still hold their reset values leaves every address mapped as in compatibility mode.
- R6: A held port write is applied on the first rising edge at which mem_cyc is low. While mem_cyc stays high, the mapping and the registers stay unchanged.
- R7: Writes with io_wr to any address other than 0x3CFF (full 16-bit compare) have no effect on the mode, the registers or the sequencer.
- R8: A port write that arrives while an earlier write is still held is dropped.
- R9: page_valid is high only when mem_cyc is high and the page driving the physical address is below PHYS_PAGES.
- R10: With io_rd high and cpu_addr = 0x3CFF, io_rdata shows the page register of the selected window. At all other times io_rdata is zero.
- R11: The command byte is laid out as follows: bit 7 turns enhanced mode on (1) or off (0), bit 6 = 1 announces a page byte, and bits 1:0 select the window. Turning enhanced mode off returns to compatibility mapping and keeps the register contents.
- R12: After a command with bit 6 clear, the next port write is taken as a command, not as a page byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for memory and for I/O port decode |
| mem_cyc | input | 1 | High while a memory cycle is in progress |
| io_wr | input | 1 | I/O write strobe, one cycle per completed write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read-back of the selected page register |
| phys_addr | output | 22 | Physical memory address |
| page_valid | output | 1 | Memory cycle targets an installed page |

## Verification
The bench loads every 8-bit value into every window. It checks the mapped window, a second window that must stay unchanged, and page_valid at the edge of the installed range. A mapper that routed the wrong register, or compared the range against the wrong page, shows up in that sweep. The bench also holds mem_cyc high across a page write and sends a second write during the hold. A design that applied the update early, or that let the late byte overwrite the held one, gives the wrong address once the bus goes idle. Other cases confirm that writes to a neighbouring port address are ignored. They also confirm that a command without the load flag leaves the sequencer expecting another command, and that registers loaded in compatibility mode stay hidden until enable.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;

    typedef enum logic [1:0] {
        ST_CMD       = 2'd0,
        ST_CMD_HOLD  = 2'd1,
        ST_PAGE      = 2'd2,
        ST_PAGE_HOLD = 2'd3
    } port_state_e;

endpackage

// File: rtl/page_mapper_port_seq.sv
module page_mapper_port_seq
    import page_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_PORT = 16'h3CFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              mem_cyc,
    output logic [DATA_W-1:0] held_q,
    output logic              cmd_commit,
    output logic              page_commit
);
    localparam int LOAD_BIT = DATA_W - 2;

    port_state_e state_q, state_d;
    logic        wr_hit;
    logic        accept;

    assign wr_hit = io_wr && (cpu_addr == CFG_PORT);
    assign accept = wr_hit && ((state_q == ST_CMD) || (state_q == ST_PAGE));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (accept) held_q <= io_wdata;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD:       if (wr_hit) state_d = ST_CMD_HOLD;
            ST_CMD_HOLD:  if (!mem_cyc) state_d = held_q[LOAD_BIT] ? ST_PAGE : ST_CMD;
            ST_PAGE:      if (wr_hit) state_d = ST_PAGE_HOLD;
            ST_PAGE_HOLD: if (!mem_cyc) state_d = ST_CMD;
            default:      state_d = ST_CMD;
        endcase
    end

    always_comb begin
        cmd_commit  = 1'b0;
        page_commit = 1'b0;
        unique case (state_q)
            ST_CMD_HOLD:  cmd_commit  = !mem_cyc;
            ST_PAGE_HOLD: page_commit = !mem_cyc;
            default: ;
        endcase
    end

endmodule

// File: rtl/page_mapper_page_file.sv
module page_mapper_page_file #(
    parameter int WIN_BITS = 2,
    parameter int PAGE_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_commit,
    input  logic                           page_commit,
    input  logic [PAGE_W-1:0]              held,
    output logic                           enh_q,
    output logic [WIN_BITS-1:0]            sel_q,
    output logic [(1<<WIN_BITS)*PAGE_W-1:0] pages_flat
);
    localparam int NUM_WIN = 1 << WIN_BITS;
    localparam int EN_BIT  = PAGE_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enh_q <= 1'b0;
            sel_q <= '0;
        end else if (cmd_commit) begin
            enh_q <= held[EN_BIT];
            sel_q <= held[WIN_BITS-1:0];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [PAGE_W-1:0] page_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q <= PAGE_W'(w);
            else if (page_commit && (sel_q == WIN_BITS'(w)))
                page_q <= held;
        end
        assign pages_flat[w*PAGE_W +: PAGE_W] = page_q;
    end

endmodule

// File: rtl/page_mapper_xlate.sv
module page_mapper_xlate #(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 2,
    parameter int PAGE_W     = 8,
    parameter int PHYS_PAGES = 256
) (
    input  logic [ADDR_W-1:0]               cpu_addr,
    input  logic                            mem_cyc,
    input  logic                            enh,
    input  logic [(1<<WIN_BITS)*PAGE_W-1:0] pages_flat,
    output logic [PAGE_W+ADDR_W-WIN_BITS-1:0] phys_addr,
    output logic                            page_valid
);
    localparam int OFF_W = ADDR_W - WIN_BITS;

    logic [WIN_BITS-1:0] win;
    logic [PAGE_W-1:0]   page_sel;
    logic                in_range;

    assign win      = cpu_addr[ADDR_W-1 -: WIN_BITS];
    assign page_sel = enh ? pages_flat[win*PAGE_W +: PAGE_W] : PAGE_W'(win);
    assign phys_addr = {page_sel, cpu_addr[OFF_W-1:0]};

    if (PHYS_PAGES >= (1 << PAGE_W)) begin : g_full
        assign in_range = 1'b1;
    end else begin : g_part
        assign in_range = ({1'b0, page_sel} < (PAGE_W+1)'(PHYS_PAGES));
    end

    assign page_valid = mem_cyc && in_range;

endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 2,
    parameter int PAGE_W     = 8,
    parameter int PHYS_PAGES = 256,
    parameter logic [ADDR_W-1:0] CFG_PORT = 16'h3CFF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 cpu_addr,
    input  logic                              mem_cyc,
    input  logic                              io_wr,
    input  logic                              io_rd,
    input  logic [PAGE_W-1:0]                 io_wdata,
    output logic [PAGE_W-1:0]                 io_rdata,
    output logic [PAGE_W+ADDR_W-WIN_BITS-1:0] phys_addr,
    output logic                              page_valid
);
    localparam int NUM_WIN = 1 << WIN_BITS;

    logic [PAGE_W-1:0]          held_q;
    logic                       cmd_commit;
    logic                       page_commit;
    logic                       enh_q;
    logic [WIN_BITS-1:0]        sel_q;
    logic [NUM_WIN*PAGE_W-1:0]  pages_flat;
    logic                       rd_hit;

    page_mapper_port_seq #(
        .ADDR_W(ADDR_W), .DATA_W(PAGE_W), .CFG_PORT(CFG_PORT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .mem_cyc(mem_cyc), .held_q(held_q),
        .cmd_commit(cmd_commit), .page_commit(page_commit)
    );

    page_mapper_page_file #(
        .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W)
    ) u_pages (
        .clk(clk), .rst_n(rst_n), .cmd_commit(cmd_commit),
        .page_commit(page_commit), .held(held_q), .enh_q(enh_q),
        .sel_q(sel_q), .pages_flat(pages_flat)
    );

    page_mapper_xlate #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W),
        .PHYS_PAGES(PHYS_PAGES)
    ) u_xlate (
        .cpu_addr(cpu_addr), .mem_cyc(mem_cyc), .enh(enh_q),
        .pages_flat(pages_flat), .phys_addr(phys_addr),
        .page_valid(page_valid)
    );

    assign rd_hit   = io_rd && (cpu_addr == CFG_PORT);
    assign io_rdata = rd_hit ? pages_flat[sel_q*PAGE_W +: PAGE_W] : '0;

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 2,
    parameter int PAGE_W   = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [ADDR_W-1:0]                 cpu_addr,
    input logic                              mem_cyc,
    input logic                              io_rd,
    input logic [PAGE_W-1:0]                 io_rdata,
    input logic [PAGE_W+ADDR_W-WIN_BITS-1:0] phys_addr,
    input logic                              page_valid,
    input logic                              enh_q,
    input logic [(1<<WIN_BITS)*PAGE_W-1:0]   pages_flat
);
    localparam int OFF_W = ADDR_W - WIN_BITS;

    a_r1_compat_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_q |-> phys_addr[PAGE_W+OFF_W-1:OFF_W] == PAGE_W'(cpu_addr[ADDR_W-1:OFF_W]));

    a_r4_window0_route: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_q && cpu_addr[ADDR_W-1:OFF_W] == '0)
        |-> phys_addr[PAGE_W+OFF_W-1:OFF_W] == pages_flat[PAGE_W-1:0]);

    a_r6_no_update_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |=> ($stable(pages_flat) && $stable(enh_q)));

    a_r9_valid_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        page_valid |-> mem_cyc);

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

endmodule

bind page_mapper page_mapper_chk #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_cyc(mem_cyc),
    .io_rd(io_rd), .io_rdata(io_rdata), .phys_addr(phys_addr),
    .page_valid(page_valid), .enh_q(enh_q), .pages_flat(pages_flat)
);

// File: tb/sim_page_mapper.sv
module sim_page_mapper;
    localparam int LIMIT = 40;
    localparam logic [15:0] PORT = 16'h3CFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mem_cyc = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [21:0] phys_addr;
    logic        page_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] mpg [4];
    bit         menh;

    always #10 clk = ~clk;

    page_mapper #(.PHYS_PAGES(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_cyc(mem_cyc),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .phys_addr(phys_addr), .page_valid(page_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; cpu_addr = '0;
        @(negedge clk);
    endtask

    task automatic cmd(input bit en, input bit load, input logic [1:0] w);
        io_write(PORT, {en, load, 4'b0, w});
    endtask

    task automatic set_page(input logic [1:0] w, input logic [7:0] p);
        cmd(menh, 1'b1, w);
        io_write(PORT, p);
        mpg[w] = p;
    endtask

    function automatic logic [21:0] expect_phys(input logic [15:0] a);
        logic [7:0] pg;
        pg = menh ? mpg[a[15:14]] : {6'b0, a[15:14]};
        return {pg, a[13:0]};
    endfunction

    task automatic check_map(input string req, input logic [15:0] a);
        cpu_addr = a; mem_cyc = 1'b1;
        #1;
        check(req, 32'(phys_addr), 32'(expect_phys(a)));
        check(req, 32'(page_valid), 32'(expect_phys(a)[21:14] < 8'(LIMIT)));
        mem_cyc = 1'b0;
        #1;
    endtask

    task automatic check_read(input string req, input logic [7:0] exp);
        cpu_addr = PORT; io_rd = 1'b1;
        #1;
        check(req, 32'(io_rdata), 32'(exp));
        io_rd = 1'b0; cpu_addr = '0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mpg[i] = 8'(i);
        menh = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state (mode, selected window, io_rdata idle)
        check("R2 idle rdata", 32'(io_rdata), 0);
        check_read("R2 reset sel0", 8'd0);
        // R1: compatibility sweep over address high bits
        for (int a = 0; a < 65536; a += 1021) check_map("R1 compat", 16'(a));
        // R2: read back every reset register (R10 read path)
        for (int w = 0; w < 4; w++) begin
            cmd(1'b0, 1'b0, 2'(w));
            check_read("R2 R10 reset reg", 8'(w));
        end
        // R10: wrong read address gives zero
        cpu_addr = 16'h3CFE; io_rd = 1'b1; #1;
        check("R10 other addr", 32'(io_rdata), 0);
        io_rd = 1'b0; #1;

        // R3: load in compat mode, mapping unchanged
        set_page(2'd1, 8'h25);
        check_map("R3 hidden load", 16'h4123);
        check_map("R3 hidden load", 16'h7FFF);

        // R5: enable with identity registers
        mpg[1] = 8'd1;
        set_page(2'd1, 8'd1);
        cmd(1'b1, 1'b0, 2'd0); menh = 1'b1;
        for (int a = 0; a < 65536; a += 4099) check_map("R5 enable identity", 16'(a));

        // R4 R9: exhaustive page sweep on every window
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 256; p++) begin
                set_page(2'(w), 8'(p));
                check_map("R4 R9 sweep", {2'(w), 14'((p * 97 + w * 13) & 16'h3FFF)});
                check_map("R4 other win", {2'(w + 1), 14'(p)});
            end
        end
        // R9: boundary of installed range
        set_page(2'd2, 8'(LIMIT - 1));
        check_map("R9 last valid", 16'h8000);
        set_page(2'd2, 8'(LIMIT));
        check_map("R9 first invalid", 16'hBFFF);
        cpu_addr = 16'h8000; mem_cyc = 1'b0; #1;
        check("R9 no cycle", 32'(page_valid), 0);

        // R6 R8: deferral during memory cycle, late write dropped
        set_page(2'd3, 8'h11);
        cmd(1'b1, 1'b1, 2'd3);
        mem_cyc = 1'b1;
        cpu_addr = PORT; io_wdata = 8'h2A; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        @(negedge clk);
        cpu_addr = PORT; io_wdata = 8'h33; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        repeat (3) @(negedge clk);
        cpu_addr = 16'hC005; #1;
        check("R6 held during cycle", 32'(phys_addr), 32'({8'h11, 14'h0005}));
        mem_cyc = 1'b0;
        @(negedge clk);
        mpg[3] = 8'h2A;
        check_map("R6 R8 applied after cycle", 16'hC005);
        // R12 state back to command: a command write now
        cmd(1'b1, 1'b0, 2'd3);
        check_read("R8 reg3", 8'h2A);

        // R7: writes to other addresses ignored
        io_write(16'h3CFE, 8'h00);
        check_map("R7 enable kept", 16'hC001);
        cmd(1'b1, 1'b1, 2'd0);
        io_write(16'h7CFF, 8'h05);
        io_write(PORT, 8'h07); mpg[0] = 8'h07;
        check_map("R7 page from port only", 16'h0010);

        // R12: command without load; next write is a command
        cmd(1'b1, 1'b0, 2'd2);
        io_write(PORT, 8'h81);
        check_read("R12 sel moved to 1", mpg[1]);
        check_map("R12 win2 kept", 16'h8002);

        // R11: disable returns to compat, registers kept
        cmd(1'b0, 1'b0, 2'd0); menh = 1'b0;
        check_map("R11 compat again", 16'hC0F0);
        check_map("R11 compat again", 16'h0001);
        check_read("R11 reg0 kept", 8'h07);
        cmd(1'b1, 1'b0, 2'd0); menh = 1'b1;
        check_map("R11 re-enable", 16'h0002);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule